// File: doc/BRIEF.md
# Permission-Checked Set-Associative Tag Directory

This block keeps the tag and state store for a set-associative cache. For every way of every set it stores three things: the line address, a 3-bit access permission and a lock owner. The data array sits outside the block. It has two ports that work side by side.

The update port allocates a line, frees a line, rewrites a permission, and sets or clears a lock owner. The lookup port searches one set. It reports:
- presence and the matching way;
- whether the request type is allowed under the stored permission;
- whether the set could accept that address;
- whether a given context holds the lock;
- whether the line is busy;
- the line address held in a victim way chosen by an outside replacement policy.

Each lookup hit sends a touch strobe carrying the set and way, so that the policy can update its recency state. Any illegal update raises an error pulse and leaves the store unchanged.

Lookup results are registered. They appear one cycle after the request. When an update and a lookup arrive in the same cycle, the lookup is evaluated against the store as the update leaves it.

Top module: `tag_dir`

## Requirements
- R1: The line address is addr >> log2(LINE_BYTES). The set is addr[IDX_LSB +: log2(SETS)], where SETS = CACHE_BYTES / WAYS / LINE_BYTES. SETS must be a power of two greater than one. With the default configuration the set is addr[4:2] and the byte-offset bits addr[1:0] have no effect.
- R2: A lookup hits only when an occupied way of the set holds the same line address and its permission is not NotPresent. Permission codes are NotPresent=0, Invalid=1, ReadOnly=2, ReadWrite=3, Busy=4.
- R3: A hit on a ReadWrite line grants every request type. Request types are load=0, instruction fetch=1, store=2.
- R4: A hit on a ReadOnly line grants load and instruction fetch only. Invalid and Busy lines grant nothing, and a miss is never granted.
- R5: A lookup that hits pulses touch_o for one cycle, aligned with rsp_valid_o, carrying the set and way of the hit. A miss gives no touch.
- R6: avail_o is 1 when some way of the set holds the looked-up line address (at any permission) or when some way is empty or NotPresent.
- R7: Update op 1 (allocate) writes into the lowest-numbered way that is empty or NotPresent. It stores the line address with permission Invalid and leaves the line unlocked.
- R8: Allocating a line that is already present, or allocating into a set with no empty or NotPresent way, pulses err_o one cycle later and changes nothing.
- R9: The other update ops act only on a present line; a miss pulses err_o. Op 2 empties the way. Op 3 writes upd_perm_i. Op 4 stores upd_ctx_i as lock owner. Op 5 unlocks. Op 0 and codes 6 and 7 do nothing.
- R10: locked_o is 1 only on a hit whose line is locked and whose stored owner equals lk_ctx_i.
- R11: idle_o is 1 on a hit whose permission is not Busy, and 0 otherwise.
- R12: All lookup outputs are registered and valid in the cycle after lk_valid_i. A lookup issued in the same cycle as an update sees the store after that update.
- R13: victim_line_o gives the line address held in way victim_way_i of the looked-up set, or 0 when that way is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_op_i | input | 3 | Update operation code |
| upd_addr_i | input | ADDR_W | Address for the update |
| upd_perm_i | input | 3 | Permission written by op 3 |
| upd_ctx_i | input | CTX_W | Lock owner written by op 4 |
| lk_valid_i | input | 1 | Lookup request strobe |
| lk_addr_i | input | ADDR_W | Lookup address |
| lk_type_i | input | 2 | Lookup request type |
| lk_ctx_i | input | CTX_W | Context tested against the lock owner |
| victim_way_i | input | WAY_W | Way chosen by the replacement policy |
| rsp_valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Line present |
| grant_o | output | 1 | Access allowed |
| way_o | output | WAY_W | Way of the hit |
| avail_o | output | 1 | Set can accept the address |
| locked_o | output | 1 | Line locked by lk_ctx_i |
| idle_o | output | 1 | Present line not Busy |
| victim_line_o | output | LA_W | Line address in the victim way |
| touch_o | output | 1 | Recency update strobe |
| touch_set_o | output | SET_W | Set of the touched line |
| touch_way_o | output | WAY_W | Way of the touched line |
| err_o | output | 1 | Illegal update |

## Verification
An update and a lookup to the same set can fall in one cycle.

The bench provokes this in two places. During the fill it allocates every way of every set while looking up the same address in the same cycle. During the permission sweep it pairs each rewrite, free and re-allocate with a lookup to the line being changed.

Each registered result is judged against a reference model of the store in the bench. The model applies the update first and then evaluates the lookup. A hit with no grant, at the way just chosen, shows that the allocate took priority.

// File: rtl/tdir_pkg.sv
package tdir_pkg;
  typedef enum logic [2:0] {
    PERM_NP   = 3'd0,
    PERM_INV  = 3'd1,
    PERM_RO   = 3'd2,
    PERM_RW   = 3'd3,
    PERM_BUSY = 3'd4
  } perm_e;

  typedef enum logic [1:0] {
    REQ_LOAD   = 2'd0,
    REQ_IFETCH = 2'd1,
    REQ_STORE  = 2'd2
  } req_e;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_DEALLOC = 3'd2,
    OP_SETPERM = 3'd3,
    OP_LOCKSET = 3'd4,
    OP_LOCKCLR = 3'd5
  } upd_op_e;
endpackage

// File: rtl/tdir_lsb_enc.sv
module tdir_lsb_enc #(
  parameter int N = 4,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/tdir_way_scan.sv
module tdir_way_scan
  import tdir_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int LA_W = 14
) (
  input  logic [WAYS-1:0]           used_i,
  input  logic [WAYS-1:0][LA_W-1:0] line_i,
  input  logic [WAYS-1:0][2:0]      perm_i,
  input  logic [LA_W-1:0]           key_i,
  output logic [WAYS-1:0]           pres_o,
  output logic [WAYS-1:0]           same_o,
  output logic [WAYS-1:0]           free_o
);
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign same_o[g] = used_i[g] && (line_i[g] == key_i);
    assign free_o[g] = !used_i[g] || (perm_i[g] == PERM_NP);
    assign pres_o[g] = same_o[g] && (perm_i[g] != PERM_NP);
  end
endmodule

// File: rtl/tag_dir.sv
module tag_dir
  import tdir_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LINE_BYTES  = 4,
  parameter int CACHE_BYTES = 128,
  parameter int WAYS        = 4,
  parameter int CTX_W       = 4,
  parameter int IDX_LSB     = $clog2(LINE_BYTES),
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int SETS       = CACHE_BYTES / (WAYS * LINE_BYTES),
  localparam int SET_W      = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LA_W       = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        upd_op_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [2:0]        upd_perm_i,
  input  logic [CTX_W-1:0]  upd_ctx_i,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic [1:0]        lk_type_i,
  input  logic [CTX_W-1:0]  lk_ctx_i,
  input  logic [WAY_W-1:0]  victim_way_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              grant_o,
  output logic [WAY_W-1:0]  way_o,
  output logic              avail_o,
  output logic              locked_o,
  output logic              idle_o,
  output logic [LA_W-1:0]   victim_line_o,
  output logic              touch_o,
  output logic [SET_W-1:0]  touch_set_o,
  output logic [WAY_W-1:0]  touch_way_o,
  output logic              err_o
);
  if (SETS < 2 || (1 << SET_W) != SETS || (1 << WAY_W) != WAYS) begin : g_bad_cfg
    $error("tag_dir: SETS and WAYS must be powers of two and SETS > 1");
  end

  // state store
  logic [WAYS-1:0]            used_q [SETS];
  logic [WAYS-1:0]            used_d [SETS];
  logic [WAYS-1:0][LA_W-1:0]  line_q [SETS];
  logic [WAYS-1:0][LA_W-1:0]  line_d [SETS];
  logic [WAYS-1:0][2:0]       perm_q [SETS];
  logic [WAYS-1:0][2:0]       perm_d [SETS];
  logic [WAYS-1:0]            lkv_q  [SETS];
  logic [WAYS-1:0]            lkv_d  [SETS];
  logic [WAYS-1:0][CTX_W-1:0] lkc_q  [SETS];
  logic [WAYS-1:0][CTX_W-1:0] lkc_d  [SETS];

  logic unused_lsb;
  assign unused_lsb = ^{upd_addr_i[OFF_W-1:0], lk_addr_i[OFF_W-1:0]};

  // update side, evaluated on current state
  logic [SET_W-1:0] u_set;
  logic [LA_W-1:0]  u_line;
  logic [WAYS-1:0]  u_pres, u_free, u_same_unused;
  logic [WAY_W-1:0] u_pw, u_fw;
  logic             u_pres_any, u_free_any;
  logic             err_d;

  assign u_set  = upd_addr_i[IDX_LSB +: SET_W];
  assign u_line = upd_addr_i[ADDR_W-1:OFF_W];

  tdir_way_scan #(.WAYS(WAYS), .LA_W(LA_W)) u_scan_upd (
    .used_i(used_q[u_set]), .line_i(line_q[u_set]), .perm_i(perm_q[u_set]),
    .key_i(u_line), .pres_o(u_pres), .same_o(u_same_unused), .free_o(u_free)
  );
  tdir_lsb_enc #(.N(WAYS), .W(WAY_W)) u_enc_upres (
    .vec_i(u_pres), .idx_o(u_pw), .any_o(u_pres_any)
  );
  tdir_lsb_enc #(.N(WAYS), .W(WAY_W)) u_enc_ufree (
    .vec_i(u_free), .idx_o(u_fw), .any_o(u_free_any)
  );

  always_comb begin
    used_d = used_q;
    line_d = line_q;
    perm_d = perm_q;
    lkv_d  = lkv_q;
    lkc_d  = lkc_q;
    err_d  = 1'b0;
    case (upd_op_i)
      3'(OP_ALLOC): begin
        if (u_pres_any || !u_free_any) err_d = 1'b1;
        else begin
          used_d[u_set][u_fw] = 1'b1;
          line_d[u_set][u_fw] = u_line;
          perm_d[u_set][u_fw] = PERM_INV;
          lkv_d[u_set][u_fw]  = 1'b0;
          lkc_d[u_set][u_fw]  = '0;
        end
      end
      3'(OP_DEALLOC): begin
        if (!u_pres_any) err_d = 1'b1;
        else begin
          used_d[u_set][u_pw] = 1'b0;
          perm_d[u_set][u_pw] = PERM_NP;
          lkv_d[u_set][u_pw]  = 1'b0;
        end
      end
      3'(OP_SETPERM): begin
        if (!u_pres_any) err_d = 1'b1;
        else perm_d[u_set][u_pw] = upd_perm_i;
      end
      3'(OP_LOCKSET): begin
        if (!u_pres_any) err_d = 1'b1;
        else begin
          lkv_d[u_set][u_pw] = 1'b1;
          lkc_d[u_set][u_pw] = upd_ctx_i;
        end
      end
      3'(OP_LOCKCLR): begin
        if (!u_pres_any) err_d = 1'b1;
        else lkv_d[u_set][u_pw] = 1'b0;
      end
      default: ;
    endcase
  end

  // lookup side, evaluated on post-update state
  logic [SET_W-1:0] l_set;
  logic [LA_W-1:0]  l_line;
  logic [WAYS-1:0]  l_pres, l_same, l_free;
  logic [WAY_W-1:0] l_pw;
  logic             l_hit;
  logic [2:0]       l_perm;
  logic             l_grant, l_locked, l_idle, l_avail;
  logic [LA_W-1:0]  l_victim;

  assign l_set  = lk_addr_i[IDX_LSB +: SET_W];
  assign l_line = lk_addr_i[ADDR_W-1:OFF_W];

  tdir_way_scan #(.WAYS(WAYS), .LA_W(LA_W)) u_scan_lk (
    .used_i(used_d[l_set]), .line_i(line_d[l_set]), .perm_i(perm_d[l_set]),
    .key_i(l_line), .pres_o(l_pres), .same_o(l_same), .free_o(l_free)
  );
  tdir_lsb_enc #(.N(WAYS), .W(WAY_W)) u_enc_lpres (
    .vec_i(l_pres), .idx_o(l_pw), .any_o(l_hit)
  );

  always_comb begin
    l_perm   = perm_d[l_set][l_pw];
    l_grant  = l_hit && ((l_perm == PERM_RW) ||
               ((l_perm == PERM_RO) &&
                (lk_type_i == REQ_LOAD || lk_type_i == REQ_IFETCH)));
    l_locked = l_hit && lkv_d[l_set][l_pw] && (lkc_d[l_set][l_pw] == lk_ctx_i);
    l_idle   = l_hit && (l_perm != PERM_BUSY);
    l_avail  = (|l_same) || (|l_free);
    l_victim = used_d[l_set][victim_way_i] ? line_d[l_set][victim_way_i] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        used_q[s] <= '0;
        line_q[s] <= '0;
        perm_q[s] <= '0;
        lkv_q[s]  <= '0;
        lkc_q[s]  <= '0;
      end
      rsp_valid_o   <= 1'b0;
      hit_o         <= 1'b0;
      grant_o       <= 1'b0;
      way_o         <= '0;
      avail_o       <= 1'b0;
      locked_o      <= 1'b0;
      idle_o        <= 1'b0;
      victim_line_o <= '0;
      touch_o       <= 1'b0;
      touch_set_o   <= '0;
      touch_way_o   <= '0;
      err_o         <= 1'b0;
    end else begin
      used_q <= used_d;
      line_q <= line_d;
      perm_q <= perm_d;
      lkv_q  <= lkv_d;
      lkc_q  <= lkc_d;
      rsp_valid_o   <= lk_valid_i;
      hit_o         <= lk_valid_i && l_hit;
      grant_o       <= lk_valid_i && l_grant;
      way_o         <= (lk_valid_i && l_hit) ? l_pw : '0;
      avail_o       <= lk_valid_i && l_avail;
      locked_o      <= lk_valid_i && l_locked;
      idle_o        <= lk_valid_i && l_idle;
      victim_line_o <= lk_valid_i ? l_victim : '0;
      touch_o       <= lk_valid_i && l_hit;
      touch_set_o   <= l_set;
      touch_way_o   <= l_pw;
      err_o         <= err_d;
    end
  end

  // assertions
  p_one_present_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(l_pres));
  p_grant_needs_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (rsp_valid_o && hit_o));
  p_touch_on_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_o |-> (rsp_valid_o && hit_o && touch_way_o == way_o));
  p_alloc_invalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == 3'(OP_ALLOC) && !u_pres_any && u_free_any) |=>
      (!err_o && perm_q[$past(u_set)][$past(u_fw)] == 3'(PERM_INV)
              && !lkv_q[$past(u_set)][$past(u_fw)]));
  p_alloc_dup_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == 3'(OP_ALLOC) && u_pres_any) |=> err_o);
  p_lock_needs_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> hit_o);
  p_idle_needs_hit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> hit_o);
  p_rsp_follows_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o);
endmodule

// File: tb/sim_tag_dir.sv
`timescale 1ns/1ps
module sim_tag_dir;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  upd_op = '0;
  logic [15:0] upd_addr = '0;
  logic [2:0]  upd_perm = '0;
  logic [3:0]  upd_ctx = '0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_addr = '0;
  logic [1:0]  lk_type = '0;
  logic [3:0]  lk_ctx = '0;
  logic [1:0]  victim_way = '0;
  logic        rsp_valid, hit, grant, avail, locked, idle, touch, err;
  logic [1:0]  way, touch_way;
  logic [13:0] victim_line;
  logic [2:0]  touch_set;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  tag_dir u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .upd_op_i(upd_op), .upd_addr_i(upd_addr), .upd_perm_i(upd_perm), .upd_ctx_i(upd_ctx),
    .lk_valid_i(lk_valid), .lk_addr_i(lk_addr), .lk_type_i(lk_type), .lk_ctx_i(lk_ctx),
    .victim_way_i(victim_way),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .grant_o(grant), .way_o(way),
    .avail_o(avail), .locked_o(locked), .idle_o(idle), .victim_line_o(victim_line),
    .touch_o(touch), .touch_set_o(touch_set), .touch_way_o(touch_way), .err_o(err)
  );

  // reference store: 8 sets x 4 ways, line = addr>>2, set = line & 7
  bit m_used [8][4];
  int m_line [8][4];
  int m_perm [8][4];
  bit m_lkv  [8][4];
  int m_lkc  [8][4];

  function automatic int A(int t, int s);
    return ((t * 8) + s) << 2;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic scan(int a, output int pw, output int fw, output bit same);
    int s = (a >> 2) & 7;
    int ln = a >> 2;
    pw = -1; fw = -1; same = 0;
    for (int w = 0; w < 4; w++) begin
      if (m_used[s][w] && m_line[s][w] == ln) same = 1;
      if (m_used[s][w] && m_line[s][w] == ln && m_perm[s][w] != 0 && pw < 0) pw = w;
      if ((!m_used[s][w] || m_perm[s][w] == 0) && fw < 0) fw = w;
    end
  endtask

  // one cycle: update + optional lookup, model applied update-first (R12)
  task automatic step(int op, int ua, int up, int uc, bit lv, int la, int lt, int lc, int vw);
    int pw, fw, s, ls;
    bit same, e_err, e_hit, e_grant, e_lock, e_idle, e_avail;
    int e_way, e_vict;
    s = (ua >> 2) & 7;
    scan(ua, pw, fw, same);
    e_err = 0;
    case (op)
      1: if (pw >= 0 || fw < 0) e_err = 1;
         else begin
           m_used[s][fw] = 1; m_line[s][fw] = ua >> 2; m_perm[s][fw] = 1;
           m_lkv[s][fw] = 0; m_lkc[s][fw] = 0;
         end
      2: if (pw < 0) e_err = 1; else begin m_used[s][pw] = 0; m_perm[s][pw] = 0; m_lkv[s][pw] = 0; end
      3: if (pw < 0) e_err = 1; else m_perm[s][pw] = up;
      4: if (pw < 0) e_err = 1; else begin m_lkv[s][pw] = 1; m_lkc[s][pw] = uc; end
      5: if (pw < 0) e_err = 1; else m_lkv[s][pw] = 0;
      default: ;
    endcase
    ls = (la >> 2) & 7;
    scan(la, pw, fw, same);
    e_hit   = pw >= 0;
    e_way   = e_hit ? pw : 0;
    e_grant = e_hit && (m_perm[ls][pw] == 3 || (m_perm[ls][pw] == 2 && lt < 2));
    e_lock  = e_hit && m_lkv[ls][pw] && m_lkc[ls][pw] == lc;
    e_idle  = e_hit && m_perm[ls][pw] != 4;
    e_avail = same || fw >= 0;
    e_vict  = m_used[ls][vw] ? m_line[ls][vw] : 0;
    upd_op = 3'(op); upd_addr = 16'(ua); upd_perm = 3'(up); upd_ctx = 4'(uc);
    lk_valid = lv; lk_addr = 16'(la); lk_type = 2'(lt); lk_ctx = 4'(lc); victim_way = 2'(vw);
    @(negedge clk);
    upd_op = '0; lk_valid = 1'b0;
    chk("R8/R9 err", err, e_err);
    if (lv) begin
      chk("R12 rsp_valid", rsp_valid, 1);
      chk("R1/R2 hit", hit, e_hit);
      chk("R3/R4 grant", grant, e_grant);
      chk("R7 way", way, e_way);
      chk("R6 avail", avail, e_avail);
      chk("R10 locked", locked, e_lock);
      chk("R11 idle", idle, e_idle);
      chk("R13 victim", victim_line, e_vict);
      chk("R5 touch", touch, e_hit);
      if (e_hit) begin
        chk("R5 touch_set", touch_set, ls);
        chk("R5 touch_way", touch_way, pw);
      end
    end else begin
      chk("R12 rsp idle", rsp_valid, 0);
      chk("R5 no touch", touch, 0);
    end
  endtask

  initial begin
    #1600000;
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset rsp", rsp_valid, 0);
    chk("R8 reset err", err, 0);
    chk("R5 reset touch", touch, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // empty store: every set misses and accepts
    for (int s = 0; s < 8; s++) step(0, 0, 0, 0, 1, A(1, s), 0, 0, 0);
    // fill with same-cycle lookup of the allocated line (R7, R12)
    for (int s = 0; s < 8; s++)
      for (int t = 0; t < 4; t++) step(1, A(t + 1, s), 0, 0, 1, A(t + 1, s), t % 3, 0, t);
    // full set and duplicate allocate (R8), offset bits ignored (R1)
    for (int s = 0; s < 8; s++) begin
      step(1, A(9, s), 0, 0, 1, A(9, s), 0, 0, 3);
      step(1, A(2, s), 0, 0, 1, A(2, s) + 3, 0, 0, 1);
    end
    // permission sweep on set 3, line tag 3 (R3, R4, R11)
    for (int p = 1; p <= 4; p++)
      for (int t = 0; t < 3; t++) step(3, A(3, 3), p, 0, 1, A(3, 3), t, 0, 2);
    // NotPresent: miss but address still accepted (R2, R6), then reuse way (R7)
    step(3, A(3, 3), 0, 0, 1, A(3, 3), 0, 0, 2);
    step(3, A(3, 3), 3, 0, 1, A(3, 3), 0, 0, 2);
    step(1, A(12, 3), 0, 0, 1, A(12, 3), 2, 0, 2);
    step(3, A(12, 3), 3, 0, 1, A(12, 3), 2, 0, 0);
    // locks (R10) and updates on absent lines (R9)
    step(4, A(1, 1), 0, 5, 1, A(1, 1), 0, 5, 0);
    step(0, 0, 0, 0, 1, A(1, 1), 0, 6, 0);
    step(4, A(1, 1), 0, 7, 1, A(1, 1), 0, 5, 0);
    step(0, 0, 0, 0, 1, A(1, 1), 0, 7, 0);
    step(5, A(1, 1), 0, 0, 1, A(1, 1), 0, 7, 0);
    step(4, A(14, 1), 0, 2, 1, A(14, 1), 0, 2, 0);
    step(5, A(14, 1), 0, 0, 0, 0, 0, 0, 0);
    step(3, A(14, 1), 3, 0, 0, 0, 0, 0, 0);
    // deallocate and reallocate into the freed way (R9, R7)
    for (int s = 0; s < 8; s++) begin
      step(2, A(2, s), 0, 0, 1, A(2, s), 0, 0, 1);
      step(2, A(2, s), 0, 0, 1, A(15, s), 0, 0, 1);
      step(1, A(15, s), 0, 0, 1, A(15, s), 0, 0, 1);
    end
    // unused op codes have no effect; victim sweep (R13)
    step(6, A(1, 0), 0, 0, 1, A(1, 0), 0, 0, 0);
    step(7, A(1, 0), 0, 0, 1, A(1, 0), 0, 0, 3);
    for (int w = 0; w < 4; w++) step(0, 0, 0, 0, 1, A(4, 0), 1, 0, w);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule